// File: doc/BRIEF.md
# GPIO Port Register Bank

This block is the register side of a general-purpose I/O port, with eight pins by default. It sits between the register port of a serial-bus target and the pin vectors of the chip's pad ring. Software sets three registers: a drive value per pin, a polarity mask for readback, and a direction per pin. It also sees a fourth, read-only view that reports the levels present on the pins.

The bus side gives a two-bit register selector, a one-cycle write strobe with a data byte, and a one-cycle read strobe. Writes land on the clock edge that samples the strobe. A read strobe loads the selected value into a holding register, and the bus side shifts that value out afterwards.

The pin inputs pass through a two-stage synchronizer before any use. The pin-level view is formed at the moment of the read strobe: the synchronized pin levels, each bit flipped where the polarity mask holds a one. A pin that the bank itself is driving reads back like any other pin.

Top module: `gpio_port_bank`

## Requirements
- R1: After reset, the drive register holds all ones, the polarity mask holds all zeros and the direction register holds all ones. All pins are therefore inputs: `pinOe` is zero and `pinOut` is all ones.
- R2: A write strobe with selector 1, 2 or 3 loads `wrData` into the drive, polarity or direction register respectively. The new value is visible at the pins and through a read from the cycle after the strobe.
- R3: A write strobe with selector 0 changes no register and no pin output.
- R4: For each bit, `pinOe` is the inverse of the direction bit (direction bit 1 = input, driver off; 0 = output). `pinOut` carries the drive register at all times.
- R5: A read with selector 1 returns the stored drive register, not the level on the pins.
- R6: A read with selector 0 returns the synchronized pin levels XOR the polarity mask. This holds for every bit, whatever its direction.
- R7: `rdData` loads on the clock edge that samples `rdEn` and holds its value while `rdEn` is low.
- R8: A pin change made just before clock edge k is not seen by a read strobe sampled at edge k+1. It is seen by a read strobe sampled at edge k+2 or later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regSel | input | 2 | Register selector: 0 pin view, 1 drive, 2 polarity, 3 direction |
| wrEn | input | 1 | One-cycle write strobe |
| wrData | input | WIDTH | Write data |
| rdEn | input | 1 | One-cycle read strobe |
| rdData | output | WIDTH | Read data holding register |
| pinIn | input | WIDTH | Pin levels from the pads (asynchronous) |
| pinOut | output | WIDTH | Per-pin drive value |
| pinOe | output | WIDTH | Per-pin output enable, high = drive |

## Verification
Register writes are due one edge after the strobe, so the bench checks `pinOut` and `pinOe` at the falling edge that follows the strobe's sampling edge. Read results appear on the edge that samples `rdEn` and are sampled at the next falling edge. Pin-view reads are due only after the two synchronizer stages have filled. The bench therefore waits three edges after each pin change before reading. It also separately probes edges k+1 and k+2 to confirm the exact latency. Expected values come from the bench's own model of the three registers: polarity results are computed as an XOR of the applied pin pattern and the written mask.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  typedef enum logic [1:0] {
    SEL_PINS = 2'd0,
    SEL_DRV  = 2'd1,
    SEL_POL  = 2'd2,
    SEL_DIR  = 2'd3
  } regSel_t;

  typedef struct packed {
    logic    ldDrv;
    logic    ldPol;
    logic    ldDir;
    logic    rdStb;
    regSel_t sel;
  } bankCtl_t;
endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] regSel,
  input  logic       wrEn,
  input  logic       rdEn,
  output bankCtl_t   ctl
);
  regSel_t selDec;

  always_comb begin
    selDec    = regSel_t'(regSel);
    ctl       = '0;
    ctl.sel   = selDec;
    ctl.rdStb = rdEn;
    if (wrEn) begin
      unique case (selDec)
        SEL_DRV:  ctl.ldDrv = 1'b1;
        SEL_POL:  ctl.ldPol = 1'b1;
        SEL_DIR:  ctl.ldDir = 1'b1;
        default:  ;
      endcase
    end
  end

  p_one_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.ldDrv, ctl.ldPol, ctl.ldDir}));

  p_pin_view_readonly_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel == 2'd0) |-> !(ctl.ldDrv || ctl.ldPol || ctl.ldDir));
endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter logic [WIDTH-1:0] DRV_RST = '1,
  parameter logic [WIDTH-1:0] POL_RST = '0,
  parameter logic [WIDTH-1:0] DIR_RST = '1
)(
  input  logic             clk,
  input  logic             rstN,
  input  bankCtl_t         ctl,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe
);
  localparam int SYNC_STAGES = 2;

  logic [WIDTH-1:0] drvReg, polReg, dirReg;
  logic [WIDTH-1:0] syncStage [SYNC_STAGES];
  logic [WIDTH-1:0] pinView;
  logic [WIDTH-1:0] rdNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncStage[s] <= '0;
    end else begin
      syncStage[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncStage[s] <= syncStage[s-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      drvReg <= DRV_RST;
      polReg <= POL_RST;
      dirReg <= DIR_RST;
    end else begin
      if (ctl.ldDrv) drvReg <= wrData;
      if (ctl.ldPol) polReg <= wrData;
      if (ctl.ldDir) dirReg <= wrData;
    end
  end

  assign pinView = syncStage[SYNC_STAGES-1] ^ polReg;

  always_comb begin
    unique case (ctl.sel)
      SEL_PINS: rdNext = pinView;
      SEL_DRV:  rdNext = drvReg;
      SEL_POL:  rdNext = polReg;
      default:  rdNext = dirReg;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdData <= '0;
    else if (ctl.rdStb) rdData <= rdNext;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign pinOut[i] = drvReg[i];
    assign pinOe[i]  = ~dirReg[i];
  end

  p_dir_to_oe_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.ldDir |=> (pinOe == ~$past(wrData)));

  p_drv_to_pin_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.ldDrv |=> (pinOut == $past(wrData)));

  p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.rdStb |=> $stable(rdData));

  p_no_load_keeps_oe_r3: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.ldDir |=> $stable(pinOe));
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
  import gpio_bank_pkg::*;
#(
  parameter int WIDTH = 8
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       regSel,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe
);
  bankCtl_t ctl;

  gpio_bank_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .regSel (regSel),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .ctl    (ctl)
  );

  gpio_bank_dp #(.WIDTH(WIDTH)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .wrData (wrData),
    .pinIn  (pinIn),
    .rdData (rdData),
    .pinOut (pinOut),
    .pinOe  (pinOe)
  );
endmodule

// File: tb/sim_gpio_port_bank.sv
module sim_gpio_port_bank;
  localparam int  W      = 8;
  localparam time PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [1:0]   regSel = '0;
  logic         wrEn = 1'b0;
  logic [W-1:0] wrData = '0;
  logic         rdEn = 1'b0;
  logic [W-1:0] rdData;
  logic [W-1:0] pinIn = '0;
  logic [W-1:0] pinOut, pinOe;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] mDrv, mPol, mDir;
  logic [W-1:0] got;

  always #(PERIOD/2) clk = ~clk;

  gpio_port_bank #(.WIDTH(W)) u0 (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [W-1:0] d);
    regSel = sel; wrData = d; wrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [W-1:0] d);
    regSel = sel; rdEn = 1'b1;
    @(posedge clk); @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic setPins(input logic [W-1:0] p);
    pinIn = p;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pinOe", pinOe, 8'h00);
    check("R1 pinOut", pinOut, 8'hFF);
    rd(2'd1, got); check("R1 drv", got, 8'hFF);
    rd(2'd2, got); check("R1 pol", got, 8'h00);
    rd(2'd3, got); check("R1 dir", got, 8'hFF);
    mDrv = 8'hFF; mPol = 8'h00; mDir = 8'hFF;

    // R2 R4: sweep every direction value, check pinOe the cycle after
    for (int v = 0; v < 256; v++) begin
      wr(2'd3, W'(v));
      check("R4 pinOe", pinOe, ~W'(v));
    end
    rd(2'd3, got); check("R2 dir readback", got, 8'hFF);
    // R2 R4: sweep every drive value
    for (int v = 0; v < 256; v++) begin
      wr(2'd1, W'(v));
      check("R4 pinOut", pinOut, W'(v));
    end
    wr(2'd1, 8'hA5); mDrv = 8'hA5;
    wr(2'd3, 8'h0F); mDir = 8'h0F;
    rd(2'd1, got); check("R2 drv readback", got, mDrv);
    rd(2'd3, got); check("R2 dir readback", got, mDir);

    // R5: drive register read ignores pin levels
    setPins(8'h3C);
    rd(2'd1, got); check("R5 drv not pins", got, 8'hA5);

    // R6: all polarity masks with varied pin pattern, mixed directions
    for (int v = 0; v < 256; v++) begin
      logic [W-1:0] p;
      p = W'((v * 37 + 11) % 256);
      wr(2'd2, W'(v));
      setPins(p);
      rd(2'd0, got); check("R6 pol sweep", got, p ^ W'(v));
    end
    // R6: all pin patterns with fixed mask
    wr(2'd2, 8'h5A); mPol = 8'h5A;
    rd(2'd2, got); check("R2 pol readback", got, mPol);
    for (int v = 0; v < 256; v++) begin
      setPins(W'(v));
      rd(2'd0, got); check("R6 pin sweep", got, W'(v) ^ mPol);
    end

    // R3: write to pin view is ignored
    wr(2'd0, 8'h00);
    check("R3 pinOut", pinOut, mDrv);
    check("R3 pinOe", pinOe, ~mDir);
    rd(2'd1, got); check("R3 drv", got, mDrv);
    rd(2'd2, got); check("R3 pol", got, mPol);
    rd(2'd3, got); check("R3 dir", got, mDir);

    // R7: rdData holds without a read strobe
    rd(2'd1, got);
    regSel = 2'd2;
    repeat (4) @(negedge clk);
    check("R7 hold", rdData, mDrv);
    wr(2'd1, 8'h11); mDrv = 8'h11;
    check("R7 hold after write", rdData, 8'hA5);

    // R8: synchronizer latency; pins set before edge k
    wr(2'd2, 8'h00); mPol = 8'h00;
    setPins(8'h00);
    pinIn = 8'hC3;          // edge k follows
    @(negedge clk);         // edge k done
    rd(2'd0, got);          // strobe sampled at edge k+1
    check("R8 not yet", got, 8'h00);
    rd(2'd0, got);          // edge k+2
    check("R8 visible", got, 8'hC3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule